// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous Static RAM

This block lets a synchronous system use an external asynchronous static RAM that holds 512K words of 16 bits, with two byte lanes. The host issues one request at a time over a valid/ready handshake. Each request is a read or a write and carries a 19-bit word address, 16 bits of write data and a two-bit lane mask. A read returns its data with a one-cycle strobe.

On the memory side the controller drives registered, active-low select, read-enable, write-enable and per-lane strobes. The bidirectional data bus is split into output data, input data and a drive enable, and the pad is built outside the block. All memory timing is given in picoseconds as parameters. Each phase of an access lasts a whole number of clock cycles, found by rounding each timing need up to the next cycle, with a floor of one cycle.

Lane mask bit 0 selects data bits 7:0 and drives the low-lane strobe. Bit 1 selects bits 15:8 and drives the high-lane strobe. The data bus is driven only inside a write pulse, while read-enable is high. A read is always followed by idle cycles with every control deasserted, so the memory can release the bus before any later write drives it.

Top module: `sram_ctl`

## Requirements
- R1: While reset is low and in the first cycle after it, req_ready is 1, rsp_valid is 0, mem_dq_oe is 0, and mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n and mem_lb_n are all 1.
- R2: req_ready is 1 only while the controller is idle. A request is taken at a rising edge where req_valid and req_ready are both 1. While req_ready is 1, mem_ce_n, mem_oe_n and mem_we_n are 1 and mem_dq_oe is 0.
- R3: A read drives the following in the cycle after it is accepted: mem_ce_n=0, mem_oe_n=0 and mem_we_n=1; mem_lb_n equal to the inverse of mask bit 0 and mem_ub_n equal to the inverse of mask bit 1; and mem_addr equal to the request address. rsp_valid is 1 for exactly one cycle, the (RD+2)-th cycle after acceptance, where RD = ceil(max(address access, read-enable access)/clock period), which is 2 by default.
- R4: A lane whose mask bit is 0 returns 8'h00 in rsp_rdata, whatever the bus carries. A lane whose mask bit is 1 returns the stored byte.
- R5: A write spends one setup cycle with mem_ce_n=0, mem_we_n=1 and the strobes from the mask. It then holds mem_we_n low for PW = ceil(max(write pulse, data setup, address-to-end)/period) cycles, which is 2 by default. During that time mem_dq_o carries the write data. mem_oe_n stays 1 for the whole write, and mem_oe_n and mem_we_n are never both 0.
- R6: mem_dq_oe is 1 only while mem_we_n=0, mem_oe_n=1 and mem_ce_n=0. mem_oe_n is already 1 in the cycle before mem_we_n falls.
- R7: A write with mask 2'b00 changes no stored byte.
- R8: After a read's capture, every control is deasserted for TA = ceil(bus release/period) cycles before req_ready returns. The bus is never driven until read-enable has been high for at least the release time.
- R9: A read keeps req_ready low for RD+1+TA cycles, and a write keeps it low for 1+PW+REC cycles, where REC = ceil(address hold/period) with a floor of 1. Both are 4 cycles by default.
- R10: Each write-enable low pulse lasts at least the write pulse time in picoseconds. mem_addr, mem_dq_o and the strobes stay stable while it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request accepted this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, masked lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory read enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_ub_n | output | 1 | High-lane strobe, active low |
| mem_lb_n | output | 1 | Low-lane strobe, active low |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_i | input | 16 | Data from memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |

## Verification
With the default parameters, a read's pins settle in the first cycle after acceptance. Its data strobe is due in the fourth cycle, and the idle handshake returns in the fifth. A write lowers write-enable in the second and third cycles and becomes idle in the fifth. The bench drives each request on a falling edge and counts falling edges from the accepting rising edge. It then compares each pin, the strobe position and the busy length against counts worked out from the ceiling rule, so every result is taken at the cycle in which it is due. A behavioural memory on the bench side commits written lanes and puts filler on lanes that are not strobed. This lets the lane masking be seen in the returned data.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  localparam int unsigned LANES  = 2;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned DATA_W = LANES * LANE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_RD_CAP,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_TURN
  } state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic lanes_on;
    logic dq_oe;
  } pin_ctl_t;

  // Whole cycles covering a time need, never less than one.
  function automatic int unsigned phase_cycles(input int unsigned need_ps,
                                               input int unsigned clk_ps);
    int unsigned n;
    n = (need_ps + clk_ps - 1) / clk_ps;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)            cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CNT_W   = 2,
  parameter int unsigned RD_CYC  = 2,
  parameter int unsigned SU_CYC  = 1,
  parameter int unsigned PW_CYC  = 2,
  parameter int unsigned REC_CYC = 1,
  parameter int unsigned TA_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             cnt_done,
  output logic             ready,
  output logic             accept,
  output logic             cap_en,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output pin_ctl_t         ctl_d
);

  state_e state_q, state_d;

  assign ready  = (state_q == ST_IDLE);
  assign accept = ready && req_valid;
  assign cap_en = (state_q == ST_RD_CAP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_WAIT;
      ST_RD_WAIT:    if (cnt_done)  state_d = ST_RD_CAP;
      ST_RD_CAP:                    state_d = ST_TURN;
      ST_TURN:       if (cnt_done)  state_d = ST_IDLE;
      ST_WR_SETUP:   if (cnt_done)  state_d = ST_WR_PULSE;
      ST_WR_PULSE:   if (cnt_done)  state_d = ST_WR_RECOVER;
      ST_WR_RECOVER: if (cnt_done)  state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  // Phase length is loaded on every state change.
  assign cnt_load = (state_d != state_q);
  always_comb begin
    unique case (state_d)
      ST_RD_WAIT:    cnt_val = CNT_W'(RD_CYC - 1);
      ST_TURN:       cnt_val = CNT_W'(TA_CYC - 1);
      ST_WR_SETUP:   cnt_val = CNT_W'(SU_CYC - 1);
      ST_WR_PULSE:   cnt_val = CNT_W'(PW_CYC - 1);
      ST_WR_RECOVER: cnt_val = CNT_W'(REC_CYC - 1);
      default:       cnt_val = '0;
    endcase
  end

  // Pin values for the state being entered; registered in the datapath.
  always_comb begin
    ctl_d = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, lanes_on: 1'b0, dq_oe: 1'b0};
    unique case (state_d)
      ST_RD_WAIT, ST_RD_CAP: begin
        ctl_d.ce_n = 1'b0; ctl_d.oe_n = 1'b0; ctl_d.lanes_on = 1'b1;
      end
      ST_WR_SETUP, ST_WR_RECOVER: begin
        ctl_d.ce_n = 1'b0; ctl_d.lanes_on = 1'b1;
      end
      ST_WR_PULSE: begin
        ctl_d.ce_n = 1'b0; ctl_d.we_n = 1'b0; ctl_d.lanes_on = 1'b1; ctl_d.dq_oe = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              cap_en,
  input  pin_ctl_t          ctl_d,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_dq_oe,
  output logic [LANES-1:0]  strb_n,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [LANES-1:0]  be_q;
  logic [LANES-1:0]  be_sel;
  logic [LANES-1:0]  strb_d;
  logic [DATA_W-1:0] rd_masked;

  assign be_sel = accept ? req_be : be_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign strb_d[g] = ~(ctl_d.lanes_on & be_sel[g]);
    assign rd_masked[g*LANE_W +: LANE_W] = be_q[g] ? mem_dq_i[g*LANE_W +: LANE_W] : '0;
  end

  // Request registers, loaded only on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dq_o <= '0;
      be_q     <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_dq_o <= req_wdata;
      be_q     <= req_be;
    end
  end

  // Memory control pins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      strb_n    <= '1;
    end else begin
      mem_ce_n  <= ctl_d.ce_n;
      mem_oe_n  <= ctl_d.oe_n;
      mem_we_n  <= ctl_d.we_n;
      mem_dq_oe <= ctl_d.dq_oe;
      strb_n    <= strb_d;
    end
  end

  // Read capture.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cap_en;
      if (cap_en) rsp_rdata <= rd_masked;
    end
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned CLK_PS     = 5000,
  parameter int unsigned T_AA_PS    = 10000,
  parameter int unsigned T_DOE_PS   = 6500,
  parameter int unsigned T_PWE_PS   = 8000,
  parameter int unsigned T_SD_PS    = 6000,
  parameter int unsigned T_AW_PS    = 8000,
  parameter int unsigned T_SA_PS    = 0,
  parameter int unsigned T_HA_PS    = 0,
  parameter int unsigned T_OEWE_PS  = 4000,
  parameter int unsigned T_REL_PS   = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [15:0]       mem_dq_o,
  input  logic [15:0]       mem_dq_i,
  output logic              mem_dq_oe
);

  localparam int unsigned RD_CYC  = phase_cycles(max2(T_AA_PS, T_DOE_PS), CLK_PS);
  localparam int unsigned SU_CYC  = phase_cycles(max2(T_SA_PS, T_OEWE_PS), CLK_PS);
  localparam int unsigned PW_CYC  = phase_cycles(max2(T_PWE_PS, max2(T_SD_PS, T_AW_PS)), CLK_PS);
  localparam int unsigned REC_CYC = phase_cycles(T_HA_PS, CLK_PS);
  localparam int unsigned TA_CYC  = phase_cycles(T_REL_PS, CLK_PS);
  localparam int unsigned MAX_CYC = max2(max2(RD_CYC, SU_CYC), max2(PW_CYC, max2(REC_CYC, TA_CYC)));
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic             accept;
  logic             cap_en;
  logic             cnt_load;
  logic             cnt_done;
  logic [CNT_W-1:0] cnt_val;
  logic [1:0]       strb_n;
  pin_ctl_t         ctl_d;

  sram_ctl_fsm #(
    .CNT_W(CNT_W), .RD_CYC(RD_CYC), .SU_CYC(SU_CYC),
    .PW_CYC(PW_CYC), .REC_CYC(REC_CYC), .TA_CYC(TA_CYC)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .cnt_done(cnt_done), .ready(req_ready), .accept(accept), .cap_en(cap_en),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .ctl_d(ctl_d)
  );

  sram_phase_cnt #(.W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .done(cnt_done)
  );

  sram_ctl_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cap_en(cap_en), .ctl_d(ctl_d),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .mem_dq_i(mem_dq_i),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe), .strb_n(strb_n),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign mem_lb_n = strb_n[0];
  assign mem_ub_n = strb_n[1];

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned CLK_PS   = 5000,
  parameter int unsigned T_PWE_PS = 8000,
  parameter int unsigned T_REL_PS = 4000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_ub_n,
  input logic              mem_lb_n,
  input logic [15:0]       mem_dq_o,
  input logic              mem_dq_oe
);

  logic [7:0] we_lo_cnt;
  logic [7:0] oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      oe_hi_cnt <= '0;
    end else begin
      if (!mem_we_n) we_lo_cnt <= (we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1;
      else           we_lo_cnt <= '0;
      if (mem_oe_n)  oe_hi_cnt <= (oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 8'd1;
      else           oe_hi_cnt <= '0;
    end
  end

  AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe)); // R2

  AST_RSP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3

  AST_NO_OE_WE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R5

  AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n && !mem_ce_n)); // R6

  AST_OE_HIGH_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_oe_n)); // R6

  AST_RELEASE_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (32'(oe_hi_cnt) * CLK_PS >= T_REL_PS)); // R8

  AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (32'(we_lo_cnt) * CLK_PS >= T_PWE_PS)); // R10

  AST_WRITE_INPUTS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$fell(mem_we_n)) |->
      ($stable(mem_addr) && $stable(mem_dq_o) && $stable(mem_ub_n) && $stable(mem_lb_n))); // R10

endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W(ADDR_W), .CLK_PS(CLK_PS), .T_PWE_PS(T_PWE_PS), .T_REL_PS(T_REL_PS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
module sram_ctl_tb_top;

  localparam int unsigned CLK_PS = 5000;

  function automatic int unsigned ceil_cyc(input int unsigned ps);
    int unsigned n;
    n = (ps + CLK_PS - 1) / CLK_PS;
    return (n == 0) ? 1 : n;
  endfunction

  localparam int unsigned EXP_RD  = ceil_cyc(10000);
  localparam int unsigned EXP_PW  = ceil_cyc(8000);
  localparam int unsigned EXP_REC = ceil_cyc(0);
  localparam int unsigned EXP_TA  = ceil_cyc(4000);

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [18:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i;
  logic        mem_dq_oe;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  sram_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_o(mem_dq_o),
    .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural memory, evaluated on falling edges while pins are steady.
  logic [15:0] mem_m [int unsigned];
  logic [15:0] sb    [int unsigned];
  int unsigned oe_hi_n = 0;
  logic        prev_oe = 1'b0;

  always @(negedge clk) begin : model
    logic [15:0] w;
    if (rst_n && !mem_ce_n && !mem_we_n && !(mem_ub_n && mem_lb_n)) begin
      check(mem_dq_oe, "R6 bus driven during write", 32'(mem_dq_oe), 32'd1);
      w = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 16'h0000;
      if (!mem_lb_n) w[7:0]  = mem_dq_o[7:0];
      if (!mem_ub_n) w[15:8] = mem_dq_o[15:8];
      mem_m[int'(mem_addr)] = w;
    end
    if (!mem_ce_n && mem_we_n && !mem_oe_n) begin
      w = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 16'h0000;
      mem_dq_i = {mem_ub_n ? 8'hA5 : w[15:8], mem_lb_n ? 8'h5A : w[7:0]};
    end else begin
      mem_dq_i = 16'hA55A;
    end
    if (rst_n && mem_dq_oe && !prev_oe)
      check(oe_hi_n * CLK_PS >= 4000, "R8 release before drive", oe_hi_n, 1);
    prev_oe = mem_dq_oe;
    oe_hi_n = mem_oe_n ? oe_hi_n + 1 : 0;
  end

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic do_write(input logic [18:0] a, input logic [15:0] d, input logic [1:0] be);
    int n = 0, we_lo = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      n++;
      if (n == 1)
        check(!mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n == ~be[0] && mem_ub_n == ~be[1]
              && mem_addr == a, "R5 setup pins",
              {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n}, {3'b011, ~be});
      if (!mem_we_n) begin
        we_lo++;
        check(mem_dq_o == d && mem_oe_n, "R5 data in pulse", mem_dq_o, d);
      end
    end while (!req_ready && n < 64);
    check(we_lo == EXP_PW, "R5 pulse cycles", we_lo, EXP_PW);
    check(n - 1 == 1 + EXP_PW + EXP_REC, "R9 write busy", n - 1, 1 + EXP_PW + EXP_REC);
  endtask

  task automatic do_read(input logic [18:0] a, input logic [1:0] be, output logic [15:0] q);
    int n = 0, hits = 0, at = 0;
    q = '0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be; req_wdata = 16'hFFFF;
    @(posedge clk);
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      n++;
      if (n == 1)
        check(!mem_ce_n && !mem_oe_n && mem_we_n && mem_lb_n == ~be[0] && mem_ub_n == ~be[1]
              && mem_addr == a, "R3 read pins",
              {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, {3'b001, ~be});
      if (rsp_valid) begin
        hits++; at = n; q = rsp_rdata;
        check(mem_ce_n && mem_oe_n && mem_ub_n && mem_lb_n, "R8 turnaround pins quiet",
              {mem_ce_n, mem_oe_n, mem_ub_n, mem_lb_n}, 4'hF);
      end
    end while (!req_ready && n < 64);
    check(hits == 1 && at == EXP_RD + 2, "R3 strobe position", at, EXP_RD + 2);
    check(n - 1 == EXP_RD + 1 + EXP_TA, "R9 read busy", n - 1, EXP_RD + 1 + EXP_TA);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [18:0] addrs [6];
    logic [15:0] q, exp, nv;
    addrs = '{19'h00000, 19'h00001, 19'h7FFFF, 19'h2AAAA, 19'h55555, 19'h12345};
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_be = '0; mem_dq_i = 16'hA55A;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_dq_oe && mem_ce_n && mem_oe_n && mem_we_n
          && mem_ub_n && mem_lb_n, "R1 reset state", {req_ready, rsp_valid, mem_dq_oe}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 after release",
          {req_ready, mem_ce_n, mem_oe_n, mem_we_n}, 4'hF);
    // R2: without req_valid the controller stays idle.
    repeat (3) @(negedge clk);
    check(req_ready && mem_ce_n, "R2 idle without request", {req_ready, mem_ce_n}, 2'b11);

    for (int i = 0; i < 6; i++) begin
      logic [18:0] a;
      a = addrs[i];
      nv = 16'(a * 19'd7) ^ 16'hC3A5;
      do_write(a, nv, 2'b11);
      sb[int'(a)] = nv;
      for (int wb = 0; wb < 4; wb++) begin
        nv = 16'(a + 19'(wb) * 19'h1111) ^ 16'h5E29;
        do_write(a, nv, 2'(wb));
        sb[int'(a)] = (sb[int'(a)] & ~lane_mask(2'(wb))) | (nv & lane_mask(2'(wb)));
        for (int rb = 0; rb < 4; rb++) begin
          do_read(a, 2'(rb), q);
          exp = sb[int'(a)] & lane_mask(2'(rb));
          if (wb == 0)      check(q == exp, "R7 empty mask write", q, exp);
          else if (rb != 3) check(q == exp, "R4 masked lanes", q, exp);
          else              check(q == exp, "R3 read data", q, exp);
        end
      end
    end
    // Cross-address isolation: full reads of every location.
    for (int i = 0; i < 6; i++) begin
      do_read(addrs[i], 2'b11, q);
      check(q == sb[int'(addrs[i])], "R4 final contents", q, sb[int'(addrs[i])]);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule